// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block is the host-side configuration access unit of a PCI-style host bridge. Software first programs a 32-bit configuration index through an index window. An access through a separate data window then becomes exactly one configuration request on a downstream request/response port. That request carries a translated address in the conventional bus/slot/function/register layout, a byte-lane size, a write flag and write data.

The translator accepts three index formats:

- **Pass-through.** Used when bit 31 of the index is set.
- **Type-1 style.** Used when bit 31 is clear and bit 0 is set.
- **Type-0 style.** Used for every other index. The slot is encoded as a one-hot select line in bits 31:11, and the translator converts it to a slot number by counting trailing zeros.

Read data from the downstream side is returned unchanged once it arrives.

A second, independent function is interrupt routing. The four interrupt pins of each attached device are rotated by the device's slot number onto four shared interrupt lines. The block also reports the interrupt-controller input number of the lowest active line.

Both windows are little-endian. Each window aliases one register over its whole 4 KiB region, so the caller only presents the select bit and the low three byte-offset bits.

Top module: `cfgx_top`

## Requirements
- R1: After a synchronous active-high reset, the index reads as zero, `h_done` and `d_valid` are low, and `irq_line`/`irq_id` are zero.
- R2: An index-window write (`h_sel_data`=0) updates only the byte lanes it covers, little-endian. Lane k is `h_wdata[8k+7:8k]`. Size 0 covers lane `h_off[1:0]`. Size 1 covers lanes 0–1 or 2–3 by `h_off[1]`. Sizes 2 and 3 cover all four lanes. An index-window read returns the full index one cycle after acceptance, and `h_done` pulses in that cycle.
- R3: When index bit 31 is set, the request address is the index with bits 1:0 replaced by `h_off[1:0]`.
- R4: When bit 31 is clear and bit 0 is set, the request address is the index with bits 2:0 replaced by `h_off[2:0]`.
- R5: Otherwise, address bits 31:11 hold the bit position (11..31) of the lowest set index bit among 31:11. Bits 10:8 hold index bits 10:8, bits 7:3 hold index bits 7:3, and bits 2:0 hold `h_off`.
- R6: In the type-0 case with index bits 31:11 all zero, address bits 31:11 are all ones. The remaining bits are as in R5.
- R7: A data-window access raises `d_valid` in the cycle after acceptance. Address, size, write flag and data are held stable until `d_ready`. The size is passed as 0/1/2 for 1/2/4 bytes, and size 3 goes out as 2. `h_ready` is low while a request is outstanding.
- R8: A data write completes with an `h_done` pulse in the cycle after the downstream handshake. A data read completes with `h_done` in the cycle after `d_rvalid`, with `h_rdata` equal to `d_rdata`.
- R9: Device i sits in slot FIRST_SLOT+i and drives its pin p on `dev_intx[4i+p]` (p=0 is INTA). `irq_line[l]` is the OR of every pin with (p + slot) mod 4 == l, registered one cycle.
- R10: `irq_id` is 0x1b + l for the lowest active line l, or zero when no line is active. It is registered in the same cycle as `irq_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Block can accept a host access |
| h_sel_data | input | 1 | 0 selects the index window, 1 selects the data window |
| h_write | input | 1 | 1 for a write |
| h_off | input | 3 | Low byte-offset bits within the window |
| h_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| h_wdata | input | 32 | Write data, little-endian lanes |
| h_done | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read result, valid with `h_done` |
| d_valid | output | 1 | Downstream configuration request valid |
| d_ready | input | 1 | Downstream accepts the request |
| d_addr | output | 32 | Translated configuration address |
| d_size | output | 2 | Normalised access size |
| d_write | output | 1 | Request is a write |
| d_wdata | output | 32 | Request write data |
| d_rvalid | input | 1 | Downstream read data valid |
| d_rdata | input | 32 | Downstream read data |
| dev_intx | input | NDEV*4 | Device interrupt pins, 4 per device |
| irq_line | output | 4 | Rotated shared interrupt lines |
| irq_id | output | 8 | Controller input number of the lowest active line |

## Verification
The embedded properties watch the handshake rules on every cycle:

- A pending request holds its fields stable.
- The host side is blocked while a request is outstanding.
- A read completes in the cycle after downstream data and returns that data.
- Reset clears the state.
- Narrow index writes leave the other lanes alone.
- Idle interrupt inputs give quiet lines, and any reported line ID stays within the four-entry range.

Only the bench scenarios can show that each index format yields the right address, including the multi-bit and no-bit type-0 cases. They also show the exact rotation of each pin onto a line, and the priority choice of the reported line ID.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int CFG_AW     = 32;
    localparam int CFG_DW     = 32;
    localparam int SLOT_LSB   = 11;
    localparam int FUNC_LSB   = 8;
    localparam int NLINES     = 4;
    localparam logic [7:0] IRQ_ID_BASE = 8'h1b;

    typedef enum logic [1:0] {
        FMT_PASS = 2'd0,
        FMT_TYPE1 = 2'd1,
        FMT_TYPE0 = 2'd2
    } idx_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } host_state_e;

    typedef struct packed {
        logic [CFG_AW-1:0] addr;
        logic [1:0]        size;
        logic              write;
        logic [CFG_DW-1:0] wdata;
    } cfg_req_t;

    function automatic logic [1:0] norm_size(input logic [1:0] s);
        return (s == 2'd3) ? 2'd2 : s;
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] s, input logic [1:0] off);
        logic [3:0] m;
        case (s)
            2'd0:    m = 4'b0001 << off;
            2'd1:    m = off[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg
    import cfgx_pkg::*;
#(
    parameter int DW = CFG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    size,
    input  logic [1:0]    off,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] idx_q
);
    localparam int NLANE = DW / 8;

    logic [3:0] mask;
    assign mask = lane_mask(size, off);

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                idx_q[8*k +: 8] <= '0;
            else if (wr_en && mask[k])
                idx_q[8*k +: 8] <= wdata[8*k +: 8];
        end
    end

    // R2
    lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && size == 2'd0 && off == 2'd0) |=> (idx_q[DW-1:8] == $past(idx_q[DW-1:8])));

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
    import cfgx_pkg::*;
#(
    parameter int AW = CFG_AW
) (
    input  logic [AW-1:0] idx,
    input  logic [2:0]    acc_lo,
    output logic [AW-1:0] addr,
    output idx_fmt_e      fmt
);
    localparam int SW = AW - SLOT_LSB;

    logic [SW-1:0] slot_pos;
    logic          slot_hit;

    // lowest set bit among the one-hot select field, as an absolute position
    always_comb begin
        slot_pos = '1;
        slot_hit = 1'b0;
        for (int b = AW - 1; b >= SLOT_LSB; b--) begin
            if (idx[b]) begin
                slot_pos = SW'(b);
                slot_hit = 1'b1;
            end
        end
    end

    always_comb begin
        if (idx[AW-1]) begin
            fmt  = FMT_PASS;
            addr = {idx[AW-1:2], acc_lo[1:0]};
        end else if (idx[0]) begin
            fmt  = FMT_TYPE1;
            addr = {idx[AW-1:3], acc_lo};
        end else begin
            fmt  = FMT_TYPE0;
            addr = {(slot_hit ? slot_pos : {SW{1'b1}}),
                    idx[SLOT_LSB-1:FUNC_LSB], idx[7:3], acc_lo};
        end
    end

endmodule

// File: rtl/cfgx_irq_route.sv
module cfgx_irq_route
    import cfgx_pkg::*;
#(
    parameter int NDEV       = 4,
    parameter int FIRST_SLOT = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NDEV*4-1:0] dev_intx,
    output logic [NLINES-1:0] irq_line,
    output logic [7:0]        irq_id
);
    logic [NLINES-1:0] rot [NDEV];
    logic [NLINES-1:0] line_c;
    logic [7:0]        id_c;

    for (genvar i = 0; i < NDEV; i++) begin : g_dev
        localparam int SHIFT = (FIRST_SLOT + i) % NLINES;
        for (genvar l = 0; l < NLINES; l++) begin : g_line
            assign rot[i][l] = dev_intx[i*4 + ((l + NLINES - SHIFT) % NLINES)];
        end
    end

    always_comb begin
        line_c = '0;
        for (int i = 0; i < NDEV; i++)
            line_c |= rot[i];
        id_c = '0;
        for (int l = NLINES - 1; l >= 0; l--)
            if (line_c[l]) id_c = IRQ_ID_BASE + 8'(l);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_line <= '0;
            irq_id   <= '0;
        end else begin
            irq_line <= line_c;
            irq_id   <= id_c;
        end
    end

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_intx == '0) |=> (irq_line == '0));

    // R10
    irq_id_range_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_line != '0) |-> (irq_id >= IRQ_ID_BASE && irq_id <= IRQ_ID_BASE + 8'd3));

endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
    import cfgx_pkg::*;
#(
    parameter int NDEV       = 4,
    parameter int FIRST_SLOT = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_valid,
    output logic              h_ready,
    input  logic              h_sel_data,
    input  logic              h_write,
    input  logic [2:0]        h_off,
    input  logic [1:0]        h_size,
    input  logic [31:0]       h_wdata,
    output logic              h_done,
    output logic [31:0]       h_rdata,
    output logic              d_valid,
    input  logic              d_ready,
    output logic [31:0]       d_addr,
    output logic [1:0]        d_size,
    output logic              d_write,
    output logic [31:0]       d_wdata,
    input  logic              d_rvalid,
    input  logic [31:0]       d_rdata,
    input  logic [NDEV*4-1:0] dev_intx,
    output logic [3:0]        irq_line,
    output logic [7:0]        irq_id
);
    host_state_e state;
    cfg_req_t    req_q;
    logic        done_q;
    logic [31:0] rdata_q;
    logic [31:0] idx_q;
    logic [31:0] xl_addr;
    idx_fmt_e    xl_fmt;
    logic        accept;
    logic        idx_we;

    assign h_ready = (state == ST_IDLE);
    assign accept  = h_valid && h_ready;
    assign idx_we  = accept && !h_sel_data && h_write;

    cfgx_index_reg #(.DW(32)) u_idx (
        .clk   (clk),
        .rst   (rst),
        .wr_en (idx_we),
        .size  (h_size),
        .off   (h_off[1:0]),
        .wdata (h_wdata),
        .idx_q (idx_q)
    );

    cfgx_xlate #(.AW(32)) u_xl (
        .idx    (idx_q),
        .acc_lo (h_off),
        .addr   (xl_addr),
        .fmt    (xl_fmt)
    );

    cfgx_irq_route #(.NDEV(NDEV), .FIRST_SLOT(FIRST_SLOT)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .dev_intx (dev_intx),
        .irq_line (irq_line),
        .irq_id   (irq_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done_q  <= 1'b0;
            rdata_q <= '0;
            req_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (!h_sel_data) begin
                            done_q  <= 1'b1;
                            rdata_q <= h_write ? 32'd0 : idx_q;
                        end else begin
                            req_q.addr  <= xl_addr;
                            req_q.size  <= norm_size(h_size);
                            req_q.write <= h_write;
                            req_q.wdata <= h_wdata;
                            state       <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (d_ready) begin
                        if (req_q.write) begin
                            done_q  <= 1'b1;
                            rdata_q <= 32'd0;
                            state   <= ST_IDLE;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (d_rvalid) begin
                        done_q  <= 1'b1;
                        rdata_q <= d_rdata;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign d_valid = (state == ST_REQ);
    assign d_addr  = req_q.addr;
    assign d_size  = req_q.size;
    assign d_write = req_q.write;
    assign d_wdata = req_q.wdata;
    assign h_done  = done_q;
    assign h_rdata = rdata_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (idx_q == 32'd0 && !h_done && !d_valid));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_addr) && $stable(d_wdata) && $stable(d_size)));

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> !h_ready);

    // R8
    rd_return_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && d_rvalid) |=> (h_done && h_rdata == $past(d_rdata)));

    // R3
    pass_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && h_sel_data && xl_fmt == FMT_PASS) |=> (d_addr[31:2] == idx_q[31:2]));

endmodule

// File: tb/sim_cfgx_top.sv
`timescale 1ns/1ps
module sim_cfgx_top;
    localparam int NDEV = 4;
    localparam int FIRST_SLOT = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic h_valid = 0, h_sel_data = 0, h_write = 0;
    logic [2:0] h_off = 0;
    logic [1:0] h_size = 0;
    logic [31:0] h_wdata = 0;
    logic h_ready, h_done;
    logic [31:0] h_rdata;
    logic d_valid, d_write;
    logic d_ready = 0, d_rvalid = 0;
    logic [31:0] d_addr, d_wdata;
    logic [31:0] d_rdata = 0;
    logic [1:0] d_size;
    logic [NDEV*4-1:0] dev_intx = '0;
    logic [3:0] irq_line;
    logic [7:0] irq_id;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    logic [31:0] idx_m = 0;

    always #2.5 clk = ~clk;

    cfgx_top #(.NDEV(NDEV), .FIRST_SLOT(FIRST_SLOT)) u0 (
        .clk(clk), .rst(rst), .h_valid(h_valid), .h_ready(h_ready),
        .h_sel_data(h_sel_data), .h_write(h_write), .h_off(h_off),
        .h_size(h_size), .h_wdata(h_wdata), .h_done(h_done), .h_rdata(h_rdata),
        .d_valid(d_valid), .d_ready(d_ready), .d_addr(d_addr), .d_size(d_size),
        .d_write(d_write), .d_wdata(d_wdata), .d_rvalid(d_rvalid), .d_rdata(d_rdata),
        .dev_intx(dev_intx), .irq_line(irq_line), .irq_id(irq_id));

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_addr(input logic [31:0] ix, input logic [2:0] lo);
        logic [31:0] r;
        int pos;
        if (ix[31]) return {ix[31:2], lo[1:0]};
        if (ix[0]) return {ix[31:3], lo};
        pos = -1;
        for (int b = 11; b < 32; b++) if (ix[b] && pos < 0) pos = b;
        r = {24'd0, ix[7:3], lo} | {21'd0, ix[10:8], 8'd0};
        if (pos < 0) r = r | 32'hFFFF_F800;
        else r = r | (32'(pos) << 11);
        return r;
    endfunction

    function automatic logic [31:0] ref_lanes(input logic [31:0] old, input logic [31:0] wd,
                                              input logic [1:0] sz, input logic [1:0] off);
        logic [31:0] r = old;
        for (int k = 0; k < 4; k++) begin
            bit hit;
            if (sz == 0) hit = (k == off);
            else if (sz == 1) hit = ((k / 2) == off[1]);
            else hit = 1;
            if (hit) r[8*k +: 8] = wd[8*k +: 8];
        end
        return r;
    endfunction

    function automatic logic [3:0] ref_lines(input logic [NDEV*4-1:0] v);
        logic [3:0] r = 0;
        for (int i = 0; i < NDEV; i++)
            for (int p = 0; p < 4; p++)
                if (v[i*4+p]) r[(p + FIRST_SLOT + i) % 4] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] ref_id(input logic [3:0] l);
        for (int k = 0; k < 4; k++) if (l[k]) return 8'h1b + 8'(k);
        return 8'h00;
    endfunction

    // presents one host access; returns at the negedge after acceptance
    task automatic host_cmd(input bit sel, input bit wr, input logic [2:0] off,
                            input logic [1:0] sz, input logic [31:0] wd);
        while (!h_ready) @(negedge clk);
        h_valid = 1; h_sel_data = sel; h_write = wr; h_off = off; h_size = sz; h_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        h_valid = 0;
    endtask

    task automatic idx_write(input logic [31:0] wd, input logic [1:0] off, input logic [1:0] sz);
        host_cmd(0, 1, {1'b0, off}, sz, wd);
        idx_m = ref_lanes(idx_m, wd, sz, off);
        check(h_done === 1'b1, "R2 index write done", {31'd0, h_done}, 32'd1);
    endtask

    task automatic idx_read();
        host_cmd(0, 0, 3'd0, 2'd2, 32'd0);
        check(h_done === 1'b1 && h_rdata === idx_m, "R2 index readback", h_rdata, idx_m);
    endtask

    task automatic data_access(input bit wr, input logic [2:0] off, input logic [1:0] sz,
                               input logic [31:0] wd, input logic [31:0] rv,
                               input int rdy_dly, input int rsp_dly, input string tag);
        logic [31:0] ea;
        ea = ref_addr(idx_m, off);
        host_cmd(1, wr, off, sz, wd);
        check(d_valid === 1'b1, "R7 request raised", {31'd0, d_valid}, 32'd1);
        for (int k = 0; k < rdy_dly; k++) begin
            @(negedge clk);
            check(d_valid === 1'b1 && d_addr === ea, "R7 request held", d_addr, ea);
        end
        d_ready = 1;
        check(d_addr === ea, tag, d_addr, ea);
        check(d_size === ((sz == 2'd3) ? 2'd2 : sz) && d_write === wr, "R7 size/flag",
              {29'd0, d_write, d_size}, {29'd0, wr, ((sz == 2'd3) ? 2'd2 : sz)});
        if (wr) check(d_wdata === wd, "R7 write data", d_wdata, wd);
        @(posedge clk);
        @(negedge clk);
        d_ready = 0;
        if (wr) begin
            check(h_done === 1'b1, "R8 write done", {31'd0, h_done}, 32'd1);
        end else begin
            check(h_done === 1'b0, "R8 read not early", {31'd0, h_done}, 32'd0);
            for (int k = 0; k < rsp_dly; k++) @(negedge clk);
            d_rvalid = 1; d_rdata = rv;
            @(posedge clk);
            @(negedge clk);
            d_rvalid = 0;
            check(h_done === 1'b1 && h_rdata === rv, "R8 read data", h_rdata, rv);
        end
    endtask

    task automatic irq_apply(input logic [NDEV*4-1:0] v, input string tag);
        logic [3:0] el;
        dev_intx = v;
        el = ref_lines(v);
        @(posedge clk);
        @(negedge clk);
        check(irq_line === el, {tag, " R9 lines"}, {28'd0, irq_line}, {28'd0, el});
        check(irq_id === ref_id(el), {tag, " R10 id"}, {24'd0, irq_id}, {24'd0, ref_id(el)});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check(h_done === 1'b0 && d_valid === 1'b0, "R1 outputs idle", {30'd0, h_done, d_valid}, 32'd0);
        check(irq_line === 4'd0 && irq_id === 8'd0, "R1 irq idle", {20'd0, irq_id, irq_line}, 32'd0);
        idx_read();

        // R2 lane writes
        idx_write(32'hA1B2C3D4, 2'd0, 2'd2); idx_read();
        idx_write(32'h000000EE, 2'd0, 2'd0); idx_read();
        idx_write(32'h55000000, 2'd3, 2'd0); idx_read();
        idx_write(32'h77660000, 2'd2, 2'd1); idx_read();
        idx_write(32'h00009988, 2'd1, 2'd1); idx_read();
        idx_write(32'h0F0F0F0F, 2'd2, 2'd3); idx_read();

        // R3 pass-through
        idx_write(32'h8000_1234, 2'd0, 2'd2);
        data_access(0, 3'd7, 2'd0, 0, 32'hDEADBEEF, 2, 3, "R3 pass address");
        // R4 type-1
        idx_write(32'h0012_3455, 2'd0, 2'd2);
        data_access(1, 3'd6, 2'd1, 32'hCAFE0000, 0, 0, 0, "R4 type1 address");
        // R5 type-0, single slot bit and several bits
        idx_write(32'h0000_8AFC, 2'd0, 2'd2);
        data_access(0, 3'd3, 2'd3, 0, 32'h12345678, 0, 0, "R5 type0 address");
        idx_write(32'h4010_0000, 2'd0, 2'd2);
        data_access(1, 3'd1, 2'd2, 32'h01020304, 0, 1, 0, "R5 type0 lowest slot");
        idx_write(32'h4000_0000, 2'd0, 2'd2);
        data_access(0, 3'd0, 2'd0, 0, 32'hFFFF0000, 0, 2, "R5 type0 top slot");
        // R6 no slot bit
        idx_write(32'h0000_05A8, 2'd0, 2'd2);
        data_access(0, 3'd5, 2'd0, 0, 32'h0BADF00D, 1, 1, "R6 empty slot");

        // random data-window traffic
        for (int n = 0; n < 150; n++) begin
            logic [31:0] iv;
            int mode;
            mode = $urandom % 4;
            iv = $urandom;
            if (mode == 0) iv[31] = 1'b1;
            else if (mode == 1) begin iv[31] = 1'b0; iv[0] = 1'b1; end
            else if (mode == 2) begin iv[31] = 1'b0; iv[0] = 1'b0; end
            else begin iv[31:11] = 21'd1 << ($urandom % 20); iv[0] = 1'b0; end
            idx_write(iv, 2'd0, 2'd2);
            data_access(1'($urandom), 3'($urandom), 2'($urandom), $urandom, $urandom,
                        $urandom % 3, $urandom % 3, "R5 random translate");
        end

        // R9/R10 interrupt rotation
        irq_apply(16'h0000, "idle");
        for (int i = 0; i < NDEV; i++)
            for (int p = 0; p < 4; p++)
                irq_apply(16'd1 << (i*4 + p), "single pin");
        irq_apply(16'h8421, "mixed");
        for (int n = 0; n < 40; n++) irq_apply(16'($urandom), "random");
        irq_apply(16'h0000, "quiet");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule